// File: doc/BRIEF.md
# Clock Generator Control Target on a Two-Wire Serial Bus

This block is a two-wire serial bus target (I2C, 7-bit addressing, standard and fast rates) that gives a host access to twelve byte-wide control and status registers of a clock generator. SCL and SDA arrive as plain inputs and are oversampled by a much faster system clock. The target pulls SDA low through an output enable, which models an open-drain pad. A select pin chooses between two device addresses, so two such generators can share one bus.

The host starts a write by sending a register index. Any further data bytes go to consecutive registers. A read returns bytes from the current index onward. The loop-control and phase-control registers are double-buffered. Host writes land in a shadow copy, and the copy that drives the clock generator changes only when the host writes the matching commit bit to a command register. The same command register issues one-clock software reset pulses to the loop section and to the phase section. A lock/reference output carries either the lock status or the reference input, as selected by a control bit.

Top module: `clkgen_i2c_target`

## Requirements
- R1: With `addr_sel` low the target acknowledges 7-bit address 26h (bytes 4Ch write, 4Dh read). With `addr_sel` high it acknowledges 27h (4Eh write, 4Fh read). For any other address it leaves SDA released through the acknowledge bit and the rest of the transfer.
- R2: The first data byte of a write sets the register index. A value of 12 or more sets index 0. Each further written byte goes to the indexed register, and the index then advances by one. A read returns the indexed register and advances in the same way. Index 11 is followed by index 0.
- R3: Register 0 is write-only and reads as 00h. Registers 1 to 8 read back the last byte written to them. Registers 9 to 11 are read-only: register 9 is {status_i[6:0], lock_i}, register 10 is status_i[14:7] and register 11 is status_i[22:15]. Writes to registers 9 to 11 are acknowledged and change nothing.
- R4: Writes to registers 1 to 4 leave `loop_ctrl_o` unchanged. A write of register 0 with bit 0 set loads `loop_ctrl_o` with {reg4, reg3, reg2, reg1}.
- R5: Writes to registers 5 and 6 leave `phase_ctrl_o` unchanged. A write of register 0 with bit 1 set loads `phase_ctrl_o` with {reg6, reg5}. Each of the two commits leaves the other active copy untouched.
- R6: Registers 7 and 8 are not double-buffered. `misc_ctrl_o` equals {reg8, reg7} from the clock after the byte is received.
- R7: A write of register 0 with bit 2 set raises `loop_rst_o` for exactly one system clock. Bit 3 does the same for `phase_rst_o`. The two pulses are independent. Commits and pulses requested in the same command byte take effect in the same system clock.
- R8: `lockref_o` equals `ref_i` when reg7 bit 0 is 1, and equals `lock_i` otherwise.
- R9: A STOP returns the target to idle, releases SDA and discards any partial byte. A START, including a repeated START, abandons the current transfer and begins a new address phase. A read ends when the host does not acknowledge a byte.
- R10: The target works at both 100 kHz and 400 kHz SCL rates, provided that every SCL high or low phase and every SDA setup lasts at least SYNC_STAGES+3 system clocks.
- R11: While `rst_n` is low, and after it is released, all registers hold 0, SDA is released and both reset pulses are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain model) |
| addr_sel | input | 1 | Selects device address 26h (0) or 27h (1) |
| lock_i | input | 1 | Loop lock status |
| ref_i | input | 1 | Reference signal for the lock/reference output |
| status_i | input | 23 | Further read-only status bits |
| loop_ctrl_o | output | 32 | Active loop control word |
| phase_ctrl_o | output | 16 | Active phase-adjust control word |
| misc_ctrl_o | output | 16 | Direct control registers 8 and 7 |
| loop_rst_o | output | 1 | One-clock loop software reset |
| phase_rst_o | output | 1 | One-clock phase software reset |
| lockref_o | output | 1 | Lock status or reference, per reg7 bit 0 |

## Verification
A single command byte can request a shadow-to-active commit and a software reset pulse, and both then act in the same system clock. The bench provokes this by changing the loop shadow and then writing a command with bits 0 and 2 set. It records the clock in which `loop_ctrl_o` changes and the clock in which `loop_rst_o` is high, and it requires the two to be equal, with exactly one pulse. A second command that carries only the phase reset bit must leave the loop pulse count and the active loop word untouched.

// File: rtl/clkgen_i2c_pkg.sv
package clkgen_i2c_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_REGS   = 12;
  localparam int PTR_W      = $clog2(NUM_REGS);
  localparam int CNT_W      = $clog2(BYTE_W + 1);
  localparam int LOOP_REGS  = 4;
  localparam int PHASE_REGS = 2;
  localparam int MISC_REGS  = 2;
  localparam int RO_REGS    = 3;
  localparam int NUM_RW     = LOOP_REGS + PHASE_REGS + MISC_REGS;
  localparam int CMD_IDX    = 0;
  localparam int RW_BASE    = 1;
  localparam int RO_BASE    = RW_BASE + NUM_RW;
  localparam int STAT_W     = RO_REGS * BYTE_W - 1;

  // command register bit positions
  localparam int CMD_COMMIT_LOOP  = 0;
  localparam int CMD_COMMIT_PHASE = 1;
  localparam int CMD_RST_LOOP     = 2;
  localparam int CMD_RST_PHASE    = 3;

  localparam logic [PTR_W-1:0]  LAST_PTR   = PTR_W'(NUM_REGS - 1);
  localparam logic [PTR_W-1:0]  CMD_PTR    = PTR_W'(CMD_IDX);
  localparam logic [BYTE_W-1:0] NUM_REGS_B = BYTE_W'(NUM_REGS);
  localparam logic [5:0]        DEV_ADDR_HI = 6'b010011;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
  } bus_state_e;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction
endpackage

// File: rtl/clkgen_i2c_sync.sv
module clkgen_i2c_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_s
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[SYNC_STAGES-1];
      sda_q    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/clkgen_i2c_link.sv
module clkgen_i2c_link
  import clkgen_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic              addr_sel,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  bus_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              rw_q, rw_d, first_q, first_d, nack_q, nack_d, oe_q, oe_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d, wa_q, wa_d;
  logic              we_q, we_d;
  logic [BYTE_W-1:0] wd_q, wd_d;
  logic              byte_done;

  assign byte_done = (cnt_q == CNT_W'(BYTE_W));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    first_d = first_q;
    nack_d  = nack_q;
    oe_d    = oe_q;
    ptr_d   = ptr_q;
    wa_d    = wa_q;
    wd_d    = wd_q;
    we_d    = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall && byte_done) begin
            if (sh_q[BYTE_W-1:1] == {DEV_ADDR_HI, addr_sel}) begin
              state_d = ST_AACK;
              oe_d    = 1'b1;
              rw_d    = sh_q[0];
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              state_d = ST_RDATA;
              sh_d    = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
            end else begin
              state_d = ST_WDATA;
              oe_d    = 1'b0;
              first_d = 1'b1;
            end
          end
        end
        ST_WDATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall && byte_done) begin
            state_d = ST_WACK;
            oe_d    = 1'b1;
            if (first_q) begin
              first_d = 1'b0;
              ptr_d   = (sh_q < NUM_REGS_B) ? sh_q[PTR_W-1:0] : '0;
            end else begin
              we_d  = 1'b1;
              wa_d  = ptr_q;
              wd_d  = sh_q;
              ptr_d = ptr_next(ptr_q);
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            state_d = ST_WDATA;
            oe_d    = 1'b0;
            cnt_d   = '0;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall && byte_done) begin
            state_d = ST_RACK;
            oe_d    = 1'b0;
            ptr_d   = ptr_next(ptr_q);
          end else if (scl_fall && cnt_q != '0) begin
            sh_d = {sh_q[BYTE_W-2:0], 1'b0};
            oe_d = ~sh_q[BYTE_W-2];
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            if (nack_q) begin
              state_d = ST_IDLE;
            end else begin
              state_d = ST_RDATA;
              cnt_d   = '0;
              sh_d    = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      nack_q  <= 1'b0;
      oe_q    <= 1'b0;
      ptr_q   <= '0;
      wa_q    <= '0;
      wd_q    <= '0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      first_q <= first_d;
      nack_q  <= nack_d;
      oe_q    <= oe_d;
      ptr_q   <= ptr_d;
      wa_q    <= wa_d;
      wd_q    <= wd_d;
      we_q    <= we_d;
    end
  end

  assign rd_ptr  = ptr_q;
  assign wr_en   = we_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;
  assign sda_oe  = oe_q;
endmodule

// File: rtl/clkgen_ctrl_regs.sv
module clkgen_ctrl_regs
  import clkgen_i2c_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [PTR_W-1:0]              wr_addr,
  input  logic [BYTE_W-1:0]             wr_data,
  input  logic [PTR_W-1:0]              rd_ptr,
  input  logic                          lock_i,
  input  logic [STAT_W-1:0]             status_i,
  output logic [BYTE_W-1:0]             rd_data,
  output logic [LOOP_REGS*BYTE_W-1:0]   loop_ctrl_o,
  output logic [PHASE_REGS*BYTE_W-1:0]  phase_ctrl_o,
  output logic [MISC_REGS*BYTE_W-1:0]   misc_ctrl_o,
  output logic                          loop_rst_o,
  output logic                          phase_rst_o
);
  localparam int PH_LO = LOOP_REGS;
  localparam int MI_LO = LOOP_REGS + PHASE_REGS;

  logic [NUM_RW-1:0][BYTE_W-1:0]     shadow_q, shadow_d;
  logic [LOOP_REGS-1:0][BYTE_W-1:0]  loop_q, loop_d;
  logic [PHASE_REGS-1:0][BYTE_W-1:0] phase_q, phase_d;
  logic [RO_REGS-1:0][BYTE_W-1:0]    ro_word;
  logic cmd_hit, lrst_d, prst_d, lrst_q, prst_q;

  assign cmd_hit = wr_en && (wr_addr == CMD_PTR);
  assign ro_word = {status_i, lock_i};

  always_comb begin
    shadow_d = shadow_q;
    for (int i = 0; i < NUM_RW; i++) begin
      if (wr_en && wr_addr == PTR_W'(RW_BASE + i)) shadow_d[i] = wr_data;
    end
    loop_d  = (cmd_hit && wr_data[CMD_COMMIT_LOOP])  ? shadow_q[PH_LO-1:0] : loop_q;
    phase_d = (cmd_hit && wr_data[CMD_COMMIT_PHASE]) ? shadow_q[MI_LO-1:PH_LO] : phase_q;
    lrst_d  = cmd_hit && wr_data[CMD_RST_LOOP];
    prst_d  = cmd_hit && wr_data[CMD_RST_PHASE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      loop_q   <= '0;
      phase_q  <= '0;
      lrst_q   <= 1'b0;
      prst_q   <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      loop_q   <= loop_d;
      phase_q  <= phase_d;
      lrst_q   <= lrst_d;
      prst_q   <= prst_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_RW; i++) begin
      if (rd_ptr == PTR_W'(RW_BASE + i)) rd_data = shadow_q[i];
    end
    for (int j = 0; j < RO_REGS; j++) begin
      if (rd_ptr == PTR_W'(RO_BASE + j)) rd_data = ro_word[j];
    end
  end

  assign loop_ctrl_o  = loop_q;
  assign phase_ctrl_o = phase_q;
  assign misc_ctrl_o  = shadow_q[NUM_RW-1:MI_LO];
  assign loop_rst_o   = lrst_q;
  assign phase_rst_o  = prst_q;
endmodule

// File: rtl/clkgen_i2c_target.sv
module clkgen_i2c_target
  import clkgen_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         scl_i,
  input  logic                         sda_i,
  output logic                         sda_oe,
  input  logic                         addr_sel,
  input  logic                         lock_i,
  input  logic                         ref_i,
  input  logic [STAT_W-1:0]            status_i,
  output logic [LOOP_REGS*BYTE_W-1:0]  loop_ctrl_o,
  output logic [PHASE_REGS*BYTE_W-1:0] phase_ctrl_o,
  output logic [MISC_REGS*BYTE_W-1:0]  misc_ctrl_o,
  output logic                         loop_rst_o,
  output logic                         phase_rst_o,
  output logic                         lockref_o
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr, rd_ptr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  clkgen_i2c_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_s(sda_s)
  );

  clkgen_i2c_link u_link (
    .clk(clk), .rst_n(rst_sync_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .addr_sel(addr_sel), .rd_data(rd_data), .rd_ptr(rd_ptr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  clkgen_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_ptr(rd_ptr), .lock_i(lock_i), .status_i(status_i),
    .rd_data(rd_data), .loop_ctrl_o(loop_ctrl_o), .phase_ctrl_o(phase_ctrl_o),
    .misc_ctrl_o(misc_ctrl_o), .loop_rst_o(loop_rst_o), .phase_rst_o(phase_rst_o)
  );

  assign lockref_o = misc_ctrl_o[0] ? ref_i : lock_i;
endmodule

// File: rtl/clkgen_i2c_target_chk.sv
module clkgen_i2c_target_chk
  import clkgen_i2c_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic                         sda_oe,
  input logic                         stop_det,
  input logic                         wr_en,
  input logic [PTR_W-1:0]             wr_addr,
  input logic [BYTE_W-1:0]            wr_data,
  input logic [PTR_W-1:0]             rd_ptr,
  input logic [LOOP_REGS*BYTE_W-1:0]  loop_ctrl_o,
  input logic [PHASE_REGS*BYTE_W-1:0] phase_ctrl_o,
  input logic                         loop_rst_o,
  input logic                         phase_rst_o
);
  a_r7_loop_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    loop_rst_o |=> !loop_rst_o);

  a_r7_phase_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rst_o |=> !phase_rst_o);

  a_r7_cmd_to_loop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == CMD_PTR && wr_data[CMD_RST_LOOP]) |=> loop_rst_o);

  a_r4_loop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(loop_ctrl_o) |-> $past(wr_en && wr_addr == CMD_PTR && wr_data[CMD_COMMIT_LOOP]));

  a_r5_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_ctrl_o) |-> $past(wr_en && wr_addr == CMD_PTR && wr_data[CMD_COMMIT_PHASE]));

  a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  a_r2_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= LAST_PTR);
endmodule

bind clkgen_i2c_target clkgen_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sda_oe(sda_oe), .stop_det(stop_det),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_ptr(rd_ptr),
  .loop_ctrl_o(loop_ctrl_o), .phase_ctrl_o(phase_ctrl_o),
  .loop_rst_o(loop_rst_o), .phase_rst_o(phase_rst_o)
);

// File: tb/tb_clkgen_i2c_target.sv
module tb_clkgen_i2c_target;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 195000;
  localparam int Q_FAST     = 20;
  localparam int Q_SLOW     = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_i, sda_oe, addr_sel = 1'b0, lock_i = 1'b0, ref_i = 1'b0;
  logic [22:0] status_i = '0;
  logic [31:0] loop_ctrl_o;
  logic [15:0] phase_ctrl_o, misc_ctrl_o;
  logic loop_rst_o, phase_rst_o, lockref_o;

  int checks = 0, errors = 0, q_len = Q_FAST;
  int cyc = 0, lrst_cnt = 0, prst_cnt = 0, lrst_cyc = -1, lchg_cyc = -2;
  logic lrst_prev = 1'b0, prst_prev = 1'b0, pulse_long = 1'b0;
  logic [31:0] loop_prev = '0;
  logic [7:0] model [0:11];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_i = sda_m & ~sda_oe;

  clkgen_i2c_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_i), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .lock_i(lock_i), .ref_i(ref_i), .status_i(status_i),
    .loop_ctrl_o(loop_ctrl_o), .phase_ctrl_o(phase_ctrl_o),
    .misc_ctrl_o(misc_ctrl_o), .loop_rst_o(loop_rst_o),
    .phase_rst_o(phase_rst_o), .lockref_o(lockref_o)
  );

  // pulse and active-word change monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (loop_rst_o) begin lrst_cnt++; lrst_cyc = cyc; if (lrst_prev) pulse_long = 1'b1; end
    if (phase_rst_o) begin prst_cnt++; if (prst_prev) pulse_long = 1'b1; end
    if (loop_ctrl_o !== loop_prev) lchg_cyc = cyc;
    loop_prev = loop_ctrl_o;
    lrst_prev = loop_rst_o;
    prst_prev = phase_rst_o;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(input int idx);
    logic [23:0] ro;
    ro = {status_i, lock_i};
    if (idx == 0) return 8'h00;
    if (idx <= 8) return model[idx];
    return ro[8*(idx-9) +: 8];
  endfunction

  function automatic logic [7:0] addr_byte(input logic rd);
    return {6'b010011, addr_sel, rd};
  endfunction

  task automatic qwait(input int n);
    repeat (n * q_len) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; qwait(1); scl_m = 1'b1; qwait(1);
    sda_m = 1'b0; qwait(1); scl_m = 1'b0; qwait(1);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; qwait(1); scl_m = 1'b1; qwait(1); sda_m = 1'b1; qwait(1);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait(1); scl_m = 1'b1; qwait(2); scl_m = 1'b0; qwait(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; qwait(1); scl_m = 1'b1; qwait(1);
    ack = sda_i; qwait(1); scl_m = 1'b0; qwait(1);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait(1); scl_m = 1'b1; qwait(1); b[i] = sda_i; qwait(1); scl_m = 1'b0;
    end
    qwait(1);
    sda_m = nack; qwait(1); scl_m = 1'b1; qwait(2); scl_m = 1'b0; qwait(1);
    sda_m = 1'b1;
  endtask

  task automatic wr_seq(input logic [7:0] ptr, input int n, input logic [63:0] data);
    logic ack;
    bus_start;
    send_byte(addr_byte(1'b0), ack);
    send_byte(ptr, ack);
    for (int i = 0; i < n; i++) send_byte(data[8*i +: 8], ack);
    bus_stop;
    qwait(1);
  endtask

  task automatic rd_seq(input logic [7:0] ptr, input int n, output logic [63:0] data);
    logic ack;
    logic [7:0] b;
    data = '0;
    bus_start;
    send_byte(addr_byte(1'b0), ack);
    send_byte(ptr, ack);
    bus_start;
    send_byte(addr_byte(1'b1), ack);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, b);
      data[8*i +: 8] = b;
    end
    bus_stop;
    qwait(1);
  endtask

  task automatic model_write(input int ptr, input int n, input logic [63:0] data);
    int p;
    p = (ptr >= 12) ? 0 : ptr;
    for (int i = 0; i < n; i++) begin
      if (p >= 1 && p <= 8) model[p] = data[8*i +: 8];
      p = (p == 11) ? 0 : p + 1;
    end
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    logic [63:0] rd;
    int lcnt0, pcnt0;
    for (int i = 0; i < 12; i++) model[i] = 8'h00;

    repeat (5) @(negedge clk);
    // R11: reset state while rst_n is held low
    check("R11 sda_oe in reset", {31'd0, sda_oe}, 32'd0);
    check("R11 loop reset pulse", {31'd0, loop_rst_o}, 32'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R11 loop_ctrl after reset", loop_ctrl_o, 32'd0);
    check("R11 phase/misc after reset", {phase_ctrl_o, misc_ctrl_o}, 32'd0);
    lock_i = 1'b1; ref_i = 1'b0; @(negedge clk);
    check("R8 lockref follows lock by default", {31'd0, lockref_o}, 32'd1);

    // R1: address decoding with addr_sel low
    bus_start; send_byte(8'h4E, ack); bus_stop;
    check("R1 27h not acked when sel low", {31'd0, ack}, 32'd1);
    check("R1 sda released after foreign address", {31'd0, sda_oe}, 32'd0);
    bus_start; send_byte(8'h4C, ack); bus_stop;
    check("R1 26h acked when sel low", {31'd0, ack}, 32'd0);

    // R4, R2: shadow writes with auto-increment, active copy unchanged
    wr_seq(8'd1, 4, 64'h44332211); model_write(1, 4, 64'h44332211);
    check("R4 loop shadow not active", loop_ctrl_o, 32'd0);
    rd_seq(8'd1, 4, rd);
    check("R2 read back auto-increment", rd[31:0], 32'h44332211);
    wr_seq(8'd0, 1, 64'h01);
    check("R4 loop commit", loop_ctrl_o, 32'h44332211);
    check("R5 phase untouched by loop commit", {16'd0, phase_ctrl_o}, 32'd0);

    // R5: phase shadow and commit
    wr_seq(8'd5, 2, 64'h5AA5); model_write(5, 2, 64'h5AA5);
    check("R5 phase shadow not active", {16'd0, phase_ctrl_o}, 32'd0);
    wr_seq(8'd0, 1, 64'h02);
    check("R5 phase commit", {16'd0, phase_ctrl_o}, 32'h5AA5);
    check("R5 loop untouched by phase commit", loop_ctrl_o, 32'h44332211);

    // R6, R8: direct registers and lock/reference routing
    wr_seq(8'd7, 2, 64'hC301); model_write(7, 2, 64'hC301);
    check("R6 misc direct", {16'd0, misc_ctrl_o}, 32'hC301);
    ref_i = 1'b0; @(negedge clk);
    check("R8 lockref routes ref low", {31'd0, lockref_o}, 32'd0);
    ref_i = 1'b1; @(negedge clk);
    check("R8 lockref routes ref high", {31'd0, lockref_o}, 32'd1);

    // R3: command reads zero, status read-only
    status_i = 23'h5A_3C_71; lock_i = 1'b1;
    rd_seq(8'd0, 1, rd);
    check("R3 command reads 00", {24'd0, rd[7:0]}, 32'd0);
    rd_seq(8'd9, 3, rd);
    check("R3 status read", rd[31:0], {8'd0, exp_reg(11), exp_reg(10), exp_reg(9)});
    wr_seq(8'd9, 3, 64'hFFFFFF);
    rd_seq(8'd9, 3, rd);
    check("R3 status write ignored", rd[31:0], {8'd0, exp_reg(11), exp_reg(10), exp_reg(9)});

    // R2: wrap 11 -> 0, out-of-range index becomes 0
    rd_seq(8'd10, 4, rd);
    check("R2 read wraps", rd[31:0], {exp_reg(1), 8'h00, exp_reg(11), exp_reg(10)});
    wr_seq(8'd8, 6, 64'h99_00_EE_DD_CC_B8); model_write(8, 6, 64'h99_00_EE_DD_CC_B8);
    rd_seq(8'd8, 1, rd);
    check("R2 write through RO then wrap, reg8", {24'd0, rd[7:0]}, {24'd0, model[8]});
    rd_seq(8'd1, 1, rd);
    check("R2 write wrapped into reg1", {24'd0, rd[7:0]}, 32'h99);
    rd_seq(8'h20, 2, rd);
    check("R2 index >= 12 maps to 0", {16'd0, rd[15:0]}, {16'd0, exp_reg(1), 8'h00});

    // R7: commit and reset pulse from the same command byte
    lcnt0 = lrst_cnt; pcnt0 = prst_cnt;
    wr_seq(8'd0, 1, 64'h05);
    check("R7 one loop pulse", lrst_cnt - lcnt0, 32'd1);
    check("R7 commit and pulse same clock", lrst_cyc, lchg_cyc);
    check("R4 loop commit with reset", loop_ctrl_o, {model[4], model[3], model[2], model[1]});
    check("R7 no phase pulse", prst_cnt - pcnt0, 32'd0);
    lcnt0 = lrst_cnt;
    wr_seq(8'd0, 1, 64'h08);
    check("R7 one phase pulse", prst_cnt - pcnt0, 32'd1);
    check("R7 phase pulse leaves loop pulse alone", lrst_cnt - lcnt0, 32'd0);
    check("R7 pulses one clock wide", {31'd0, pulse_long}, 32'd0);

    // R9: stop mid-byte discards, repeated start reads from advanced index
    bus_start; send_byte(addr_byte(1'b0), ack); send_byte(8'd1, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop; qwait(1);
    check("R9 sda released after stop", {31'd0, sda_oe}, 32'd0);
    rd_seq(8'd1, 1, rd);
    check("R9 partial byte discarded", {24'd0, rd[7:0]}, {24'd0, model[1]});
    begin
      logic [7:0] b;
      bus_start; send_byte(addr_byte(1'b0), ack); send_byte(8'd2, ack);
      send_byte(8'h5F, ack); model[2] = 8'h5F;
      bus_start; send_byte(addr_byte(1'b1), ack);
      recv_byte(1'b1, b);
      check("R9 nack ends read, sda released", {31'd0, sda_oe}, 32'd0);
      bus_stop; qwait(1);
      check("R9 repeated start then read next index", {24'd0, b}, {24'd0, model[3]});
    end

    // R10: slow-rate transfer
    q_len = Q_SLOW;
    wr_seq(8'd6, 1, 64'h6B); model_write(6, 1, 64'h6B);
    rd_seq(8'd6, 1, rd);
    check("R10 slow rate read back", {24'd0, rd[7:0]}, 32'h6B);
    q_len = Q_FAST;

    // R1: address decoding with addr_sel high
    addr_sel = 1'b1; @(negedge clk);
    bus_start; send_byte(8'h4C, ack); bus_stop;
    check("R1 26h not acked when sel high", {31'd0, ack}, 32'd1);
    bus_start; send_byte(8'h4E, ack); bus_stop;
    check("R1 27h acked when sel high", {31'd0, ack}, 32'd0);

    // constrained random shadow traffic (R2, R3, R6)
    void'($urandom(32'd5634));
    for (int it = 0; it < 6; it++) begin
      int start, n;
      logic [63:0] data;
      start = 1 + int'($urandom % 8);
      n = 1 + int'($urandom % 3);
      data = {$urandom, $urandom};
      wr_seq(8'(start), n, data); model_write(start, n, data);
      rd_seq(8'(start), n, rd);
      for (int k = 0; k < n; k++)
        check("R3 random read back", {24'd0, rd[8*k +: 8]}, {24'd0, exp_reg(start + k)});
    end
    check("R6 misc after random", {16'd0, misc_ctrl_o}, {16'd0, model[8], model[7]});
    wr_seq(8'd0, 1, 64'h03);
    check("R4 random loop commit", loop_ctrl_o, {model[4], model[3], model[2], model[1]});
    check("R5 random phase commit", {16'd0, phase_ctrl_o}, {16'd0, model[6], model[5]});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule